// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives a two-row, eight-column character display over an 8-bit parallel bus. It writes only: the read/write line is tied to write, and busy-flag polling is replaced by fixed waits counted in clock cycles. After reset it sends a fixed series of configuration commands. These set up the 8-bit interface, turn the display on with the cursor and blink off, clear the screen and choose the entry mode. When that series ends, the block lowers its busy output.

A system controller asks for a character by pulsing `req` while `busy` is low, and gives the row, the column and the character code. The block turns each request into two bus writes. The first is a set-address command carrying the display address for that cell. The second is a data write carrying the character. The rows are contiguous in the address space: row 0 covers 00h–07h and row 1 covers 08h–0Fh.

Each bus write has four phases: a set-up phase with E low and the register-select line and data already driven, an E pulse, a hold phase, and then a settling wait. The wait is longer after a clear command. The set-up, pulse, hold and wait lengths are parameters counted in clock cycles.

Top module: `lcd_char_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 1, `lcd_e` is 0 and `lcd_rw` is 0.
- R2: After reset the block performs exactly four writes with `lcd_rs`=0, in this order: 38h, 0Ch, 01h, 06h. After the fourth write completes, `busy` falls.
- R3: Every E pulse stays high for exactly `PULSE_CYC` consecutive cycles.
- R4: `lcd_rs` and `lcd_db` are unchanged for at least `SETUP_CYC` cycles before E rises. They are also unchanged while E is high and for at least `HOLD_CYC` cycles after E falls.
- R5: The low time between two E pulses is at least `HOLD_CYC`+`WAIT_CYC`+`SETUP_CYC` cycles. If the earlier write was the clear command (01h with `lcd_rs`=0), the low time is at least `HOLD_CYC`+`CLEAR_CYC`+`SETUP_CYC` cycles.
- R6: When `req` is 1 and `busy` is 0, `busy` is 1 in the next cycle. The block then performs two writes: first the set-address command (80h OR address) with `lcd_rs`=0, then the character code with `lcd_rs`=1.
- R7: The address is equal to the column for row 0 and to 08h plus the column for row 1, where the column is 0–7.
- R8: A `req` raised while `busy` is 1 is ignored. No extra bus writes follow from it.
- R9: `lcd_rw` is 0 in every cycle.
- R10: `busy` falls no earlier than `HOLD_CYC`+`WAIT_CYC` cycles after the falling edge of E for the last write of a request or of the initial series.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Character write request; only sampled while `busy` is 0 |
| row | input | 1 | Target row (0 or 1) |
| col | input | 3 | Target column (0–7) |
| char_code | input | 8 | Character code to write |
| busy | output | 1 | High during the initial series and during a request |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for character data |
| lcd_rw | output | 1 | Read/write select; always 0 (write) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 8 | Data bus; bit 0 is the LSB |

## Verification
The bound checker watches the bus timing on every cycle:
- the exact E pulse width;
- the set-up stability of `lcd_rs`/`lcd_db` before E rises;
- bus stability while E is high and for the hold time after it falls;
- that `lcd_rw` stays low;
- that `busy` rises in the cycle after an accepted request;
- that `busy` cannot fall before the hold and wait have elapsed.

Other behaviours can only be shown by the bench's scenarios, which record every bus write:
- the order and values of the initial commands;
- the longer gap after a clear;
- the address computed for each row and column;
- that requests made while busy are dropped.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int         N_INIT       = 4;
    localparam logic [7:0] CMD_SET_ADDR = 8'h80;
    localparam logic [7:0] CMD_CLEAR    = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_WAIT
    } lcd_phase_e;

    typedef enum logic [2:0] {
        SQ_INIT_ISSUE,
        SQ_INIT_WAIT,
        SQ_IDLE,
        SQ_ADDR_ISSUE,
        SQ_ADDR_WAIT,
        SQ_DATA_ISSUE,
        SQ_DATA_WAIT
    } lcd_seq_e;

    typedef struct packed {
        logic       rs;
        logic [7:0] code;
    } lcd_word_t;

    function automatic logic [7:0] init_cmd(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h38;
            2'd1:    return 8'h0C;
            2'd2:    return CMD_CLEAR;
            default: return 8'h06;
        endcase
    endfunction

    function automatic logic needs_long_wait(input lcd_word_t w);
        return (!w.rs) && (w.code == CMD_CLEAR);
    endfunction

endpackage

// File: rtl/lcd_addr_map.sv
module lcd_addr_map #(
    parameter int ROWS = 2,
    parameter int COLS = 8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [7:0]       addr
);
    always_comb begin
        addr = 8'(row) * 8'(COLS) + 8'(col);
    end
endmodule

// File: rtl/lcd_xfer.sv
module lcd_xfer
    import lcd_pkg::*;
#(
    parameter int SETUP_CYC = 6,
    parameter int PULSE_CYC = 45,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 4000,
    parameter int CLEAR_CYC = 160000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  lcd_word_t word_in,
    output lcd_word_t word_out,
    output logic      e_out,
    output logic      done
);
    localparam int M1    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int M2    = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
    localparam int M3    = (M2 > WAIT_CYC) ? M2 : WAIT_CYC;
    localparam int MAXC  = (M3 > CLEAR_CYC) ? M3 : CLEAR_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    lcd_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    lcd_word_t        word_q;
    logic             e_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            word_q <= '0;
            e_q    <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        word_q <= word_in;
                        phase  <= PH_SETUP;
                        cnt    <= CNT_W'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= CNT_W'(PULSE_CYC - 1);
                        e_q   <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= CNT_W'(HOLD_CYC - 1);
                        e_q   <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_WAIT;
                        cnt   <= needs_long_wait(word_q) ? CNT_W'(CLEAR_CYC - 1)
                                                         : CNT_W'(WAIT_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign word_out = word_q;
    assign e_out    = e_q;
    assign done     = (phase == PH_WAIT) && (cnt == '0);
endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
    import lcd_pkg::*;
#(
    parameter int ROWS = 2,
    parameter int COLS = 8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [7:0]       char_code,
    input  logic             x_done,
    output logic             start,
    output lcd_word_t        word,
    output logic             busy
);
    lcd_seq_e         state;
    logic [1:0]       idx;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [7:0]       chr_q;
    logic [7:0]       addr;

    lcd_addr_map #(.ROWS(ROWS), .COLS(COLS)) u_map (
        .row  (row_q),
        .col  (col_q),
        .addr (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_INIT_ISSUE;
            idx   <= '0;
            row_q <= '0;
            col_q <= '0;
            chr_q <= '0;
        end else begin
            case (state)
                SQ_INIT_ISSUE: state <= SQ_INIT_WAIT;
                SQ_INIT_WAIT: begin
                    if (x_done) begin
                        if (idx == 2'(N_INIT - 1)) begin
                            state <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_INIT_ISSUE;
                        end
                    end
                end
                SQ_IDLE: begin
                    if (req) begin
                        row_q <= row;
                        col_q <= col;
                        chr_q <= char_code;
                        state <= SQ_ADDR_ISSUE;
                    end
                end
                SQ_ADDR_ISSUE: state <= SQ_ADDR_WAIT;
                SQ_ADDR_WAIT:  if (x_done) state <= SQ_DATA_ISSUE;
                SQ_DATA_ISSUE: state <= SQ_DATA_WAIT;
                SQ_DATA_WAIT:  if (x_done) state <= SQ_IDLE;
                default:       state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        start = 1'b0;
        word  = '0;
        case (state)
            SQ_INIT_ISSUE: begin
                start     = 1'b1;
                word.code = init_cmd(idx);
            end
            SQ_ADDR_ISSUE: begin
                start     = 1'b1;
                word.code = CMD_SET_ADDR | addr;
            end
            SQ_DATA_ISSUE: begin
                start     = 1'b1;
                word.rs   = 1'b1;
                word.code = chr_q;
            end
            default: ;
        endcase
    end

    assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/lcd_char_writer.sv
module lcd_char_writer
    import lcd_pkg::*;
#(
    parameter int ROWS      = 2,
    parameter int COLS      = 8,
    parameter int SETUP_CYC = 6,
    parameter int PULSE_CYC = 45,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 4000,
    parameter int CLEAR_CYC = 160000,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [7:0]       char_code,
    output logic             busy,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_e,
    output logic [7:0]       lcd_db
);
    logic      x_start;
    logic      x_done;
    lcd_word_t seq_word;
    lcd_word_t bus_word;

    lcd_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .row       (row),
        .col       (col),
        .char_code (char_code),
        .x_done    (x_done),
        .start     (x_start),
        .word      (seq_word),
        .busy      (busy)
    );

    lcd_xfer #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .CLEAR_CYC (CLEAR_CYC)
    ) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .start    (x_start),
        .word_in  (seq_word),
        .word_out (bus_word),
        .e_out    (lcd_e),
        .done     (x_done)
    );

    assign lcd_rs = bus_word.rs;
    assign lcd_db = bus_word.code;
    assign lcd_rw = 1'b0;
endmodule

// File: rtl/lcd_char_writer_chk.sv
module lcd_char_writer_chk #(
    parameter int SETUP_CYC = 6,
    parameter int PULSE_CYC = 45,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 4000
) (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       busy,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] lcd_db
);
    logic [31:0] hi_cnt;
    logic [31:0] stab_cnt;
    logic [31:0] since_fall;
    logic [8:0]  prev_bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            stab_cnt   <= '0;
            since_fall <= 32'hFFFF_0000;
            prev_bus   <= '0;
        end else begin
            hi_cnt   <= lcd_e ? hi_cnt + 1 : '0;
            prev_bus <= {lcd_rs, lcd_db};
            if ({lcd_rs, lcd_db} != prev_bus) stab_cnt <= '0;
            else if (stab_cnt != 32'hFFFF_FFFF) stab_cnt <= stab_cnt + 1;
            if (lcd_e) since_fall <= '0;
            else if (since_fall != 32'hFFFF_FFFF) since_fall <= since_fall + 1;
        end
    end

    p_reset_busy_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy && !lcd_e));

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
        (!lcd_e && $past(lcd_e)) |-> ($past(hi_cnt) == 32'(PULSE_CYC - 1)));

    p_pulse_max_r3: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> (hi_cnt < 32'(PULSE_CYC)));

    p_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_e) |-> (stab_cnt >= 32'(SETUP_CYC - 1)));

    p_stable_high_r4: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_db}));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!lcd_e && ({lcd_rs, lcd_db} != prev_bus)) |-> (since_fall >= 32'(HOLD_CYC)));

    p_busy_on_req_r6: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    p_rw_low_r9: assert property (@(posedge clk) disable iff (rst)
        !lcd_rw);

    p_busy_wait_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (since_fall >= 32'(HOLD_CYC + WAIT_CYC)));
endmodule

bind lcd_char_writer lcd_char_writer_chk #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .WAIT_CYC  (WAIT_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .busy   (busy),
    .lcd_rs (lcd_rs),
    .lcd_rw (lcd_rw),
    .lcd_e  (lcd_e),
    .lcd_db (lcd_db)
);

// File: tb/lcd_char_writer_tb.sv
module lcd_char_writer_tb;
    localparam int S = 3, P = 5, H = 2, W = 20, C = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       row = 1'b0;
    logic [2:0] col = '0;
    logic [7:0] char_code = '0;
    logic       busy, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_db;

    int checks = 0, failures = 0;
    bit finished = 0;

    logic       cap_rs [0:127];
    logic [7:0] cap_db [0:127];
    int         cap_n = 0;

    always #5 clk = ~clk;

    lcd_char_writer #(
        .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .WAIT_CYC(W), .CLEAR_CYC(C)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .row(row), .col(col), .char_code(char_code),
        .busy(busy), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_addr(input logic r, input logic [2:0] c);
        return r ? (8'h08 + 8'(c)) : 8'(c);
    endfunction

    // bus monitor, sampled on the falling clock edge
    int         cyc = 0;
    logic       prev_e = 0, prev_busy = 1;
    logic [8:0] prev_bus = '0, rise_bus = '0;
    int         stab = 0, hi = 0, last_fall = 0;
    bit         have_fall = 0, last_slow = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if ({lcd_rs, lcd_db} != prev_bus) stab = 0; else stab++;
            if (lcd_rw !== 1'b0) chk(0, "R9 rw high", lcd_rw, 0);
            if (lcd_e && !prev_e) begin
                chk(stab >= S, "R4 setup", stab, S);
                if (have_fall)
                    chk(cyc - last_fall >= H + (last_slow ? C : W) + S, "R5 gap",
                        cyc - last_fall, H + (last_slow ? C : W) + S);
                rise_bus = {lcd_rs, lcd_db};
                if (cap_n < 128) begin
                    cap_rs[cap_n] = lcd_rs;
                    cap_db[cap_n] = lcd_db;
                end
                cap_n++;
                hi = 1;
            end else if (lcd_e) begin
                hi++;
            end
            if (!lcd_e && prev_e) begin
                chk(hi == P, "R3 pulse width", hi, P);
                chk({lcd_rs, lcd_db} == rise_bus, "R4 stable during pulse",
                    {lcd_rs, lcd_db}, rise_bus);
                last_fall = cyc;
                have_fall = 1;
                last_slow = (!rise_bus[8]) && (rise_bus[7:0] == 8'h01);
            end
            if (prev_busy && !busy && have_fall)
                chk(cyc - last_fall >= H + W, "R10 busy release", cyc - last_fall, H + W);
            prev_e    = lcd_e;
            prev_busy = busy;
            prev_bus  = {lcd_rs, lcd_db};
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic r, input logic [2:0] c, input logic [7:0] ch,
                            input bit poke);
        int base;
        wait_idle();
        base = cap_n;
        row = r; col = c; char_code = ch; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R6 busy after req", busy, 1);
        if (poke) begin
            repeat (S + 2) @(negedge clk);
            row = ~r; col = c + 3'd1; char_code = ~ch; req = 1'b1;  // R8 ignored
            @(negedge clk);
            req = 1'b0;
        end
        wait_idle();
        repeat (2) @(negedge clk);
        chk(cap_n == base + 2, "R6/R8 write count", cap_n - base, 2);
        if (cap_n == base + 2) begin
            chk(cap_rs[base] == 1'b0 && cap_db[base] == (8'h80 | exp_addr(r, c)),
                "R7 address command", {cap_rs[base], cap_db[base]}, {1'b0, 8'h80 | exp_addr(r, c)});
            chk(cap_rs[base+1] == 1'b1 && cap_db[base+1] == ch,
                "R6 data write", {cap_rs[base+1], cap_db[base+1]}, {1'b1, ch});
        end
    endtask

    initial begin
        logic [7:0] init_exp [0:3];
        int n0;
        init_exp[0] = 8'h38; init_exp[1] = 8'h0C; init_exp[2] = 8'h01; init_exp[3] = 8'h06;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(busy && !lcd_e && !lcd_rw, "R1 reset state", {busy, lcd_e, lcd_rw}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(busy && !lcd_e, "R1 first cycle", {busy, lcd_e}, 2'b10);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(cap_n == 4, "R2 init count", cap_n, 4);
        for (int i = 0; i < 4; i++)
            chk(cap_rs[i] == 1'b0 && cap_db[i] == init_exp[i], "R2 init command",
                {cap_rs[i], cap_db[i]}, {1'b0, init_exp[i]});
        // directed corners of the address map (R7)
        do_write(1'b0, 3'd0, 8'h41, 0);
        do_write(1'b1, 3'd7, 8'h5A, 0);
        do_write(1'b0, 3'd7, 8'h30, 1);
        do_write(1'b1, 3'd0, 8'hFF, 1);
        for (int k = 0; k < 12; k++)
            do_write(1'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
        // R8: idle bus stays quiet with no request
        n0 = cap_n;
        repeat (W * 3) @(negedge clk);
        chk(cap_n == n0 && !busy, "R8 no spurious writes", cap_n - n0, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule